// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block tracks how many bytes a DMA data phase of a storage bus controller may still move. Host software writes the byte count one byte at a time into staging registers. Issuing a command that carries the DMA flag copies the staged bytes into the working count. When a transfer starts, the block takes the smaller of the working count and the number of bytes the target still has pending. In the command phase it takes the smaller of the working count and a fixed command-buffer size instead.

The memory-side mover and the target-side protocol sit outside the block. The block offers one chunk at a time, with a length and a direction, and the mover acknowledges each chunk. The target side reports new buffer data, the end of the command, and the pending byte count, which is signed: positive for bytes coming from the target, negative for bytes going to it.

After every chunk the block decides whether completion is signalled at once or deferred until the target delivers more data. On completion it sets the terminal-count status bit, loads the bus-service interrupt code and raises the interrupt.

Top module: `dma_len_counter`

## Requirements
- R1: After reset the following are all zero: `busy`, `irq`, `tc_stat`, `intr_code`, `work_cnt`, `remaining`, `pend_cnt` and `chunk_valid`.
- R2: `prog_wr[k]` stores `prog_byte` as staged byte k (bits 8k+7..8k). `issue` with `issue_dma`=1 copies all staged bytes into `work_cnt`. `issue` with `issue_dma`=0 leaves `work_cnt` unchanged.
- R3: `start` while idle sets `busy`, clears `tc_stat` and loads `remaining` with min(L, |pending|), where L is `work_cnt`, or 65536 when `work_cnt` is zero.
- R4: `start` with `cmd_phase`=1 loads `remaining` with min(L, 32) and offers a single chunk of that length with `chunk_to_tgt`=1. Its acknowledge clears `busy` and `pend_cnt` without signalling completion.
- R5: `start` while `busy` is ignored, so `remaining` is unchanged.
- R6: Each offered chunk has length min(`remaining`, available target bytes) and `chunk_to_tgt`=1 exactly when pending is negative. The acknowledge subtracts the length from `remaining` and from the available bytes. It adds the length to pending for to-target chunks and subtracts it for from-target chunks.
- R7: Completion sets `tc_stat`, sets `intr_code`=0x10 and `irq`, zeroes `work_cnt`, clears `busy` and pulses `seq_flags_clr` for exactly one cycle.
- R8: After a chunk acknowledge, completion is immediate if target bytes are still available. It is also immediate if the available bytes reach zero, the chunk went from the target, `remaining` is zero and pending is nonzero.
- R9: After a chunk acknowledge that empties the target bytes, completion is deferred if the chunk went to the target, if `remaining` is nonzero, or if pending is zero. A later `tgt_arrive` while `busy`, with `remaining` zero and pending at or below zero, signals the deferred completion.
- R10: `tgt_end` while `busy` zeroes `remaining` and `pend_cnt` and signals completion.
- R11: `pend_set` is ignored while `busy`, so `pend_cnt` is unchanged.
- R12: `irq_ack` clears `irq` and `intr_code` when no completion happens in the same cycle.
- R13: `tgt_next` pulses for one cycle after a chunk acknowledge that empties the available target bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_wr | input | CNT_W/8 | Per-byte write strobes for the staged count |
| prog_byte | input | 8 | Byte written to the staged count |
| issue | input | 1 | Command issued |
| issue_dma | input | 1 | Issued command carries the DMA flag |
| pend_set | input | 1 | Load the pending byte count |
| pend_val | input | CNT_W+2 | Signed pending count (negative means toward the target) |
| start | input | 1 | Start a transfer |
| cmd_phase | input | 1 | The starting transfer fetches command bytes |
| tgt_arrive | input | 1 | New target buffer data is available |
| tgt_len | input | CNT_W+1 | Bytes in the new target buffer |
| tgt_end | input | 1 | Target reports the end of the command |
| chunk_valid | output | 1 | A chunk is offered to the mover |
| chunk_len | output | CNT_W+1 | Length of the offered chunk |
| chunk_to_tgt | output | 1 | Chunk moves from memory toward the target |
| chunk_done | input | 1 | Mover acknowledges the offered chunk |
| tgt_next | output | 1 | Target buffer emptied; request more data |
| irq_ack | input | 1 | Host reads and clears the interrupt code |
| busy | output | 1 | Transfer in progress |
| work_cnt | output | CNT_W | Working count register |
| remaining | output | CNT_W+1 | Bytes the current transfer may still move |
| pend_cnt | output | CNT_W+2 | Signed pending byte count |
| tc_stat | output | 1 | Terminal-count status bit |
| irq | output | 1 | Interrupt request |
| intr_code | output | 8 | Interrupt code register |
| seq_flags_clr | output | 1 | One-cycle pulse that zeroes the sequence-step and flags registers |

## Verification
The bench builds the block with CNT_W=16, CMD_CAP=32 and the zero-means-maximum variant. This makes an all-zero count reachable as 65536 bytes, and a staged count of 100 shows the 32-byte command cap. The 18-bit signed pending count lets a pending magnitude of 70000 exceed 65536, so the programmed length becomes the limit. Scenarios drive both chunk directions, multi-chunk transfers that wait for target data, every deferral branch, and an early end reported by the target.

// File: rtl/dmalc_pkg.sv
package dmalc_pkg;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] INTR_BUS_SVC = 8'h10;
endpackage

// File: rtl/dmalc_min.sv
module dmalc_min #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   assign y = (a < b) ? a : b;
endmodule

// File: rtl/dmalc_len_calc.sv
module dmalc_len_calc #(
   parameter int CNT_W       = 16,
   parameter int CMD_CAP     = 32,
   parameter bit ZERO_IS_MAX = 1'b1
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic             cmd_phase,
   input  logic [CNT_W+1:0] pend,
   output logic [CNT_W:0]   eff
);
   localparam int LW = CNT_W + 1;
   localparam int PW = CNT_W + 2;

   logic [LW-1:0] prog_len;
   logic [PW-1:0] mag;
   logic [PW-1:0] cap;
   logic [LW-1:0] cap_fit;

   generate
      if (ZERO_IS_MAX) begin : g_zero_max
         assign prog_len = (cnt == '0) ? (LW'(1) << CNT_W) : LW'(cnt);
      end else begin : g_zero_zero
         assign prog_len = LW'(cnt);
      end
   endgenerate

   assign mag     = pend[PW-1] ? (~pend + PW'(1)) : pend;
   assign cap     = cmd_phase ? PW'(CMD_CAP) : mag;
   assign cap_fit = cap[PW-1] ? prog_len : cap[LW-1:0];

   dmalc_min #(.W(LW)) u_min (.a(prog_len), .b(cap_fit), .y(eff));
endmodule

// File: rtl/dmalc_status.sv
module dmalc_status
   import dmalc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_acc,
   input  logic              fin,
   input  logic              irq_ack,
   output logic              tc_stat,
   output logic              irq,
   output logic [BYTE_W-1:0] intr_code,
   output logic              seq_flags_clr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_stat       <= 1'b0;
         irq           <= 1'b0;
         intr_code     <= '0;
         seq_flags_clr <= 1'b0;
      end else begin
         seq_flags_clr <= fin;
         if (fin) begin
            tc_stat   <= 1'b1;
            irq       <= 1'b1;
            intr_code <= INTR_BUS_SVC;
         end else begin
            if (start_acc) tc_stat <= 1'b0;
            if (irq_ack) begin
               irq       <= 1'b0;
               intr_code <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/dma_len_counter.sv
module dma_len_counter
   import dmalc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int CMD_CAP     = 32,
   parameter bit ZERO_IS_MAX = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CNT_W/BYTE_W-1:0]  prog_wr,
   input  logic [BYTE_W-1:0]        prog_byte,
   input  logic                     issue,
   input  logic                     issue_dma,
   input  logic                     pend_set,
   input  logic [CNT_W+1:0]         pend_val,
   input  logic                     start,
   input  logic                     cmd_phase,
   input  logic                     tgt_arrive,
   input  logic [CNT_W:0]           tgt_len,
   input  logic                     tgt_end,
   output logic                     chunk_valid,
   output logic [CNT_W:0]           chunk_len,
   output logic                     chunk_to_tgt,
   input  logic                     chunk_done,
   output logic                     tgt_next,
   input  logic                     irq_ack,
   output logic                     busy,
   output logic [CNT_W-1:0]         work_cnt,
   output logic [CNT_W:0]           remaining,
   output logic [CNT_W+1:0]         pend_cnt,
   output logic                     tc_stat,
   output logic                     irq,
   output logic [BYTE_W-1:0]        intr_code,
   output logic                     seq_flags_clr
);
   localparam int NB = CNT_W / BYTE_W;
   localparam int LW = CNT_W + 1;
   localparam int PW = CNT_W + 2;

   generate
      if (CNT_W < BYTE_W || (CNT_W % BYTE_W) != 0) begin : g_bad_width
         $error("CNT_W must be a nonzero multiple of the byte width");
      end
      if (CMD_CAP < 1 || CMD_CAP >= (1 << LW)) begin : g_bad_cap
         $error("CMD_CAP must be positive and fit the length width");
      end
   endgenerate

   logic                 cmd_mode;
   logic [LW-1:0]        avail;
   logic signed [PW-1:0] pend_q;
   logic [LW-1:0]        eff_len;
   logic [LW-1:0]        sized;
   logic                 fin;

   // staged and working count, one byte lane per generate iteration
   generate
      for (genvar k = 0; k < NB; k++) begin : g_lane
         logic [BYTE_W-1:0] stage_q;
         logic [BYTE_W-1:0] work_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            stage_q <= '0;
            else if (prog_wr[k])   stage_q <= prog_byte;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  work_q <= '0;
            else if (fin)                work_q <= '0;
            else if (issue && issue_dma) work_q <= stage_q;
         end
         assign work_cnt[k*BYTE_W +: BYTE_W] = work_q;
      end
   endgenerate

   dmalc_len_calc #(.CNT_W(CNT_W), .CMD_CAP(CMD_CAP), .ZERO_IS_MAX(ZERO_IS_MAX)) u_len (
      .cnt(work_cnt), .cmd_phase(cmd_phase), .pend(pend_q), .eff(eff_len));

   dmalc_min #(.W(LW)) u_chunk_size (.a(remaining), .b(avail), .y(sized));

   // effect of the chunk being acknowledged
   logic                 done_ev;
   logic signed [PW-1:0] step;
   logic [LW-1:0]        rem_nx;
   logic [LW-1:0]        av_nx;
   logic signed [PW-1:0] pend_nx;
   logic                 defer;
   logic                 fin_chunk;
   logic                 fin_arrive;
   logic                 fin_end;
   logic                 cmd_finish;
   logic                 start_acc;
   logic                 pend_le0;

   assign done_ev    = chunk_valid && chunk_done;
   assign step       = $signed(PW'(chunk_len));
   assign rem_nx     = remaining - chunk_len;
   assign av_nx      = avail - chunk_len;
   assign pend_nx    = chunk_to_tgt ? (pend_q + step) : (pend_q - step);
   assign defer      = chunk_to_tgt || (rem_nx != '0) || (pend_nx == '0);
   assign pend_le0   = pend_q[PW-1] || (pend_q == '0);
   assign fin_chunk  = done_ev && !cmd_mode && ((av_nx != '0) || !defer);
   assign fin_arrive = tgt_arrive && busy && !cmd_mode && !chunk_valid
                       && (remaining == '0) && pend_le0;
   assign fin_end    = tgt_end && busy;
   assign fin        = fin_chunk || fin_arrive || fin_end;
   assign cmd_finish = done_ev && cmd_mode;
   assign start_acc  = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy         <= 1'b0;
         cmd_mode     <= 1'b0;
         remaining    <= '0;
         avail        <= '0;
         pend_q       <= '0;
         chunk_valid  <= 1'b0;
         chunk_len    <= '0;
         chunk_to_tgt <= 1'b0;
         tgt_next     <= 1'b0;
      end else begin
         tgt_next <= done_ev && !cmd_mode && (av_nx == '0);

         if (start_acc)                busy <= 1'b1;
         else if (fin || cmd_finish)   busy <= 1'b0;

         if (start_acc) cmd_mode <= cmd_phase;

         if (fin_end)        remaining <= '0;
         else if (start_acc) remaining <= eff_len;
         else if (done_ev)   remaining <= rem_nx;

         if (fin_end)                  avail <= '0;
         else if (tgt_arrive)          avail <= tgt_len;
         else if (done_ev && !cmd_mode) avail <= av_nx;

         if (fin_end || cmd_finish)     pend_q <= '0;
         else if (done_ev)              pend_q <= pend_nx;
         else if (pend_set && !busy)    pend_q <= $signed(pend_val);

         if (done_ev || fin_end) begin
            chunk_valid <= 1'b0;
         end else if (!chunk_valid && busy && (remaining != '0)
                      && (cmd_mode || (avail != '0))) begin
            chunk_valid  <= 1'b1;
            chunk_len    <= cmd_mode ? remaining : sized;
            chunk_to_tgt <= cmd_mode || pend_q[PW-1];
         end
      end
   end

   assign pend_cnt = pend_q;

   dmalc_status u_status (
      .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .fin(fin), .irq_ack(irq_ack),
      .tc_stat(tc_stat), .irq(irq), .intr_code(intr_code), .seq_flags_clr(seq_flags_clr));
endmodule

// File: rtl/dmalc_checker.sv
module dmalc_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             tc_stat,
   input logic             irq,
   input logic             irq_ack,
   input logic [7:0]       intr_code,
   input logic [CNT_W-1:0] work_cnt,
   input logic [CNT_W:0]   remaining,
   input logic             chunk_valid,
   input logic [CNT_W:0]   chunk_len,
   input logic             chunk_done,
   input logic             tgt_end,
   input logic [CNT_W+1:0] pend_cnt,
   input logic             tgt_next,
   input logic             seq_flags_clr
);
   // R3: an accepted start leaves the block busy with terminal count cleared
   p_start_clears_tc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !tc_stat));

   // R5: while busy, only a chunk acknowledge or target end moves the remaining count
   p_busy_holds_rem_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !chunk_done && !tgt_end) |=> $stable(remaining));

   // R6: an offered chunk is nonempty and never exceeds the remaining count
   p_chunk_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid |-> (chunk_len != '0 && chunk_len <= remaining));

   // R7: a new interrupt comes with the full completion update
   p_done_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (tc_stat && intr_code == 8'h10 && work_cnt == '0 && !busy));

   // R7: the register-clear strobe lasts one cycle
   p_clr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_flags_clr |=> !seq_flags_clr);

   // R11: the pending count holds while busy without a chunk acknowledge or target end
   p_pend_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !chunk_done && !tgt_end) |=> $stable(pend_cnt));

   // R12: acknowledging while idle drops the interrupt
   p_ack_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !busy) |=> (!irq && intr_code == '0));

   // R13: the refill request only follows a chunk acknowledge
   p_next_after_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_next |-> $past(chunk_done));
endmodule

bind dma_len_counter dmalc_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .tc_stat(tc_stat),
   .irq(irq), .irq_ack(irq_ack), .intr_code(intr_code), .work_cnt(work_cnt),
   .remaining(remaining), .chunk_valid(chunk_valid), .chunk_len(chunk_len),
   .chunk_done(chunk_done), .tgt_end(tgt_end), .pend_cnt(pend_cnt),
   .tgt_next(tgt_next), .seq_flags_clr(seq_flags_clr));

// File: tb/sim_dma_len_counter.sv
`timescale 1ns/1ps
module sim_dma_len_counter;
   localparam int CNT_W = 16;
   localparam int LW = CNT_W + 1;
   localparam int PW = CNT_W + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] prog_wr = '0;
   logic [7:0] prog_byte = '0;
   logic issue = 1'b0, issue_dma = 1'b0, pend_set = 1'b0;
   logic [PW-1:0] pend_val = '0;
   logic start = 1'b0, cmd_phase = 1'b0, tgt_arrive = 1'b0, tgt_end = 1'b0;
   logic [LW-1:0] tgt_len = '0;
   logic chunk_valid, chunk_to_tgt, tgt_next, busy, tc_stat, irq, seq_flags_clr;
   logic [LW-1:0] chunk_len, remaining;
   logic chunk_done = 1'b0, irq_ack = 1'b0;
   logic [CNT_W-1:0] work_cnt;
   logic [PW-1:0] pend_cnt;
   logic [7:0] intr_code;

   always #10 clk = ~clk;

   dma_len_counter #(.CNT_W(CNT_W), .CMD_CAP(32), .ZERO_IS_MAX(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .prog_wr(prog_wr), .prog_byte(prog_byte),
      .issue(issue), .issue_dma(issue_dma), .pend_set(pend_set), .pend_val(pend_val),
      .start(start), .cmd_phase(cmd_phase), .tgt_arrive(tgt_arrive), .tgt_len(tgt_len),
      .tgt_end(tgt_end), .chunk_valid(chunk_valid), .chunk_len(chunk_len),
      .chunk_to_tgt(chunk_to_tgt), .chunk_done(chunk_done), .tgt_next(tgt_next),
      .irq_ack(irq_ack), .busy(busy), .work_cnt(work_cnt), .remaining(remaining),
      .pend_cnt(pend_cnt), .tc_stat(tc_stat), .irq(irq), .intr_code(intr_code),
      .seq_flags_clr(seq_flags_clr));

   typedef struct packed { logic [LW-1:0] len; logic to_tgt; } chunk_t;
   chunk_t exp_q[$];
   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pv(input int v);
      logic [PW-1:0] t;
      t = PW'(v);
      return 32'(t);
   endfunction

   // monitor: pops the expected chunk and acknowledges it
   initial begin
      forever begin
         @(negedge clk);
         if (chunk_valid && !chunk_done) begin
            checks++;
            if (exp_q.size() == 0) begin
               fails++;
               $display("FAIL R6 unexpected chunk actual=%0h expected=none", chunk_len);
            end else begin
               chunk_t e;
               e = exp_q.pop_front();
               if (chunk_len !== e.len || chunk_to_tgt !== e.to_tgt) begin
                  fails++;
                  $display("FAIL R6 chunk actual=%0h/%0b expected=%0h/%0b",
                           chunk_len, chunk_to_tgt, e.len, e.to_tgt);
               end
            end
            chunk_done = 1'b1;
         end else begin
            chunk_done = 1'b0;
         end
      end
   end

   task automatic prog(input logic [7:0] lo, input logic [7:0] mid);
      @(negedge clk); prog_wr = 2'b01; prog_byte = lo;
      @(negedge clk); prog_wr = 2'b10; prog_byte = mid;
      @(negedge clk); prog_wr = 2'b00;
   endtask
   task automatic do_issue(input logic dma);
      @(negedge clk); issue = 1'b1; issue_dma = dma;
      @(negedge clk); issue = 1'b0; issue_dma = 1'b0;
   endtask
   task automatic do_pend(input int v);
      @(negedge clk); pend_set = 1'b1; pend_val = PW'(v);
      @(negedge clk); pend_set = 1'b0;
   endtask
   task automatic do_arrive(input int n);
      @(negedge clk); tgt_arrive = 1'b1; tgt_len = LW'(n);
      @(negedge clk); tgt_arrive = 1'b0;
   endtask
   task automatic do_start(input logic cmd);
      @(negedge clk); start = 1'b1; cmd_phase = cmd;
      @(negedge clk); start = 1'b0; cmd_phase = 1'b0;
   endtask
   task automatic do_end();
      @(negedge clk); tgt_end = 1'b1;
      @(negedge clk); tgt_end = 1'b0;
   endtask
   task automatic do_ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask
   task automatic wait_idle();
      int n = 0;
      while (busy && n < 100) begin @(negedge clk); n++; end
   endtask
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", 32'(busy), 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 tc", 32'(tc_stat), 0);
      chk("R1 intr", 32'(intr_code), 0);
      chk("R1 work", 32'(work_cnt), 0);
      chk("R1 remaining", 32'(remaining), 0);
      chk("R1 pend", 32'(pend_cnt), 0);
      chk("R1 chunk_valid", 32'(chunk_valid), 0);

      // R2 staging and copy on DMA command
      prog(8'h34, 8'h12);
      do_issue(1'b0);
      chk("R2 no dma flag", 32'(work_cnt), 0);
      do_issue(1'b1);
      chk("R2 dma copy", 32'(work_cnt), 32'h1234);

      // R8 immediate completion, target data left over
      do_pend(10);
      prog(8'd4, 8'd0);
      do_issue(1'b1);
      do_arrive(8);
      exp_q.push_back('{len: LW'(4), to_tgt: 1'b0});
      do_start(1'b0);
      chk("R3 remaining", 32'(remaining), 4);
      chk("R3 busy", 32'(busy), 1);
      wait_idle();
      chk("R7 clr pulse", 32'(seq_flags_clr), 1);
      chk("R13 no refill", 32'(tgt_next), 0);
      chk("R8 irq", 32'(irq), 1);
      chk("R7 intr", 32'(intr_code), 32'h10);
      chk("R7 tc", 32'(tc_stat), 1);
      chk("R7 work zero", 32'(work_cnt), 0);
      chk("R6 pend after", 32'(pend_cnt), pv(6));
      chk("R6 remaining after", 32'(remaining), 0);
      @(negedge clk);
      chk("R7 clr one cycle", 32'(seq_flags_clr), 0);
      do_ack();
      chk("R12 irq", 32'(irq), 0);
      chk("R12 intr", 32'(intr_code), 0);

      // R8 immediate completion, buffer emptied from target with pending left
      do_pend(10);
      prog(8'd4, 8'd0);
      do_issue(1'b1);
      do_arrive(4);
      exp_q.push_back('{len: LW'(4), to_tgt: 1'b0});
      do_start(1'b0);
      chk("R3 tc cleared", 32'(tc_stat), 0);
      wait_idle();
      chk("R13 refill pulse", 32'(tgt_next), 1);
      chk("R8 irq emptied", 32'(irq), 1);
      @(negedge clk);
      chk("R13 pulse ends", 32'(tgt_next), 0);
      do_ack();

      // R10 deferral on zero pending, then target end
      do_pend(4);
      prog(8'd16, 8'd0);
      do_issue(1'b1);
      do_arrive(4);
      exp_q.push_back('{len: LW'(4), to_tgt: 1'b0});
      do_start(1'b0);
      chk("R3 min pend", 32'(remaining), 4);
      idle(6);
      chk("R9 deferred busy", 32'(busy), 1);
      chk("R9 deferred irq", 32'(irq), 0);
      do_end();
      chk("R10 irq", 32'(irq), 1);
      chk("R10 busy", 32'(busy), 0);
      chk("R10 pend", 32'(pend_cnt), 0);
      chk("R10 remaining", 32'(remaining), 0);
      do_ack();

      // R6 two to-target chunks, second waits for data
      do_pend(-6);
      prog(8'd4, 8'd0);
      do_issue(1'b1);
      do_arrive(2);
      exp_q.push_back('{len: LW'(2), to_tgt: 1'b1});
      do_start(1'b0);
      idle(6);
      chk("R6 rem mid", 32'(remaining), 2);
      chk("R6 pend mid", 32'(pend_cnt), pv(-4));
      chk("R9 waiting", 32'(irq), 0);
      exp_q.push_back('{len: LW'(2), to_tgt: 1'b1});
      do_arrive(8);
      wait_idle();
      chk("R8 to-target leftover", 32'(irq), 1);
      chk("R6 pend end", 32'(pend_cnt), pv(-2));
      do_ack();

      // R9 deferral toward target, completed by arrival; R5 and R11 while busy
      do_pend(-6);
      prog(8'd4, 8'd0);
      do_issue(1'b1);
      do_arrive(4);
      exp_q.push_back('{len: LW'(4), to_tgt: 1'b1});
      do_start(1'b0);
      idle(6);
      chk("R9 busy", 32'(busy), 1);
      chk("R9 no irq", 32'(irq), 0);
      chk("R9 pend", 32'(pend_cnt), pv(-2));
      do_start(1'b0);
      chk("R5 remaining held", 32'(remaining), 0);
      do_pend(5);
      chk("R11 pend held", 32'(pend_cnt), pv(-2));
      do_arrive(2);
      chk("R9 arrival completes", 32'(irq), 1);
      chk("R9 intr", 32'(intr_code), 32'h10);
      chk("R9 idle", 32'(busy), 0);
      do_ack();

      // R4 command phase capped at 32
      do_pend(0);
      prog(8'd100, 8'd0);
      do_issue(1'b1);
      exp_q.push_back('{len: LW'(32), to_tgt: 1'b1});
      do_start(1'b1);
      chk("R4 cap", 32'(remaining), 32);
      wait_idle();
      chk("R4 no completion", 32'(irq), 0);
      chk("R4 idle", 32'(busy), 0);
      prog(8'd20, 8'd0);
      do_issue(1'b1);
      exp_q.push_back('{len: LW'(20), to_tgt: 1'b1});
      do_start(1'b1);
      chk("R4 below cap", 32'(remaining), 20);
      wait_idle();
      chk("R4 rem after", 32'(remaining), 0);

      // R3 zero count means 65536
      prog(8'd0, 8'd0);
      do_issue(1'b1);
      do_pend(70000);
      do_arrive(0);
      do_start(1'b0);
      chk("R3 zero count", 32'(remaining), 32'h10000);
      do_end();
      chk("R10 end zero", 32'(irq), 1);
      do_ack();

      idle(4);
      chk("R6 scoreboard drained", 32'(exp_q.size()), 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule